// File: doc/BRIEF.md
# Broadcast Register Write Fan-Out

This block sits between a 32-bit write port and a row of up to fifteen frame controllers. Software writes 32-bit words into one of two windows: a register window, where the word's offset names both the target register and the word's slot in a packet, and a data window, whose packets always go to the frame-data register. Four words make a 128-bit packet. The first three are staged. Writing the word in slot 3 sends the packet to every target that is marked present, all at once, with a shared address and data bus.

The write port is a valid/ready stream. `wr_ready` falls while any target still holds an unaccepted packet, and it rises again once every present target has taken it. The master must hold `wr_valid` and its payload stable until it sees `wr_ready` at a clock edge. Each target takes its packet through its own `pkt_valid`/`pkt_ready` pair. A target whose ready is high takes the packet in the first cycle, so with all targets ready the strobe lasts exactly one cycle. Reads are not supported: they return zero and raise an error pulse.

Top module: `cfbc_bcast`

## Requirements
- R1: After reset no `pkt_valid` bit is set, `access_err` is low, `wr_ready` is high, and all three staged words are zero. A word-3 write straight after reset therefore emits zeros in bits [95:0].
- R2: The word slot is offset bits [3:2]. Slot k of a packet occupies `pkt_data` bits [32k+31:32k]. A write to slots 0 to 2 only stages the word and sets no `pkt_valid` bit.
- R3: A write to slot 3 emits a packet in the cycle after the write is accepted. In the register window (`wr_win`=0) its `pkt_addr` is offset bits [9:4].
- R4: A packet from the data window (`wr_win`=1) carries `pkt_addr` equal to `DATA_RADDR` (default 2), whatever the offset bits [9:4] are.
- R5: `pkt_valid` is raised only for the targets whose `tgt_present` bit is set at the accepted slot-3 write. With no target present, no bit is raised and `wr_ready` stays high.
- R6: Each `pkt_valid` bit stays high, with `pkt_addr` and `pkt_data` held stable, until that target's `pkt_ready` is seen high at a clock edge. When all targets are ready, the strobe lasts one cycle.
- R7: `wr_ready` is low while any target still holds a packet it has not accepted.
- R8: A read (`rd_valid`) returns `rd_data` = 0, and `access_err` is high in the following cycle.
- R9: An accepted write with `wr_strb` other than 4'hF, or with offset bits [1:0] not zero, is dropped. It changes no staged word, emits no packet, and raises `access_err` in the following cycle.
- R10: The staged words persist after a packet is emitted. A second slot-3 write reuses them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write request accepted at this edge |
| wr_win | input | 1 | 0 = register window, 1 = data window |
| wr_addr | input | 10 | Byte offset within the window (routing bits) |
| wr_data | input | 32 | Write word, little-endian |
| wr_strb | input | 4 | Byte strobes; only 4'hF is legal |
| rd_valid | input | 1 | Read request (unsupported) |
| rd_data | output | 32 | Read data, always zero |
| access_err | output | 1 | One-cycle pulse after a read or a malformed write |
| tgt_present | input | NUM_TGT | Targets that exist |
| pkt_valid | output | NUM_TGT | Per-target packet valid |
| pkt_ready | input | NUM_TGT | Per-target packet ready |
| pkt_addr | output | 6 | Shared packet register address |
| pkt_data | output | 128 | Shared packet data, slot 0 in the low word |

## Verification
A read and an accepted slot-3 write can share one cycle, so the error responder and the packet launch act on the same edge. The bench drives `rd_valid` in the same cycle as a slot-3 write. It then expects `access_err` high together with the correct packet on the target bus, so neither path disturbs the other. The random phase also mixes reads into ordinary traffic. Every error pulse is compared against the stimulus of the previous cycle.

// File: rtl/cfbc_pkg.sv
package cfbc_pkg;
  localparam int WORD_W        = 32;
  localparam int WORDS_PER_PKT = 4;
  localparam int RADDR_W       = 6;
  localparam int OFS_W         = 10;
  localparam int PKT_W         = WORD_W * WORDS_PER_PKT;
  localparam int IDX_W         = $clog2(WORDS_PER_PKT);
  localparam int STRB_W        = WORD_W / 8;

  typedef enum logic {
    WIN_REG  = 1'b0,
    WIN_DATA = 1'b1
  } win_e;

  typedef struct packed {
    logic [RADDR_W-1:0] raddr;
    logic [PKT_W-1:0]   data;
  } pkt_t;
endpackage

// File: rtl/cfbc_stage.sv
module cfbc_stage
  import cfbc_pkg::*;
#(
  parameter logic [RADDR_W-1:0] DATA_RADDR = 6'd2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_i,
  input  win_e             win_i,
  input  logic [OFS_W-1:2] ofs_i,
  input  logic [WORD_W-1:0] data_i,
  output logic             launch_o,
  output pkt_t             pkt_o
);
  localparam int LAST = WORDS_PER_PKT - 1;

  logic [IDX_W-1:0] idx;
  logic [PKT_W-1:0] lanes;

  assign idx = ofs_i[2 +: IDX_W];

  for (genvar g = 0; g < LAST; g++) begin : g_slot
    logic [WORD_W-1:0] held;
    always_ff @(posedge clk) begin
      if (!rst_n) held <= '0;
      else if (acc_i && idx == IDX_W'(g)) held <= data_i;
    end
    assign lanes[g*WORD_W +: WORD_W] = held;
  end

  // the final word passes straight through into the packet register
  assign lanes[LAST*WORD_W +: WORD_W] = data_i;

  assign launch_o    = acc_i && (idx == IDX_W'(LAST));
  assign pkt_o.data  = lanes;
  assign pkt_o.raddr = (win_i == WIN_DATA) ? DATA_RADDR : ofs_i[OFS_W-1 -: RADDR_W];

  AST_STAGE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_i |=> $stable(lanes[LAST*WORD_W-1:0])); // R10
endmodule

// File: rtl/cfbc_fanout.sv
module cfbc_fanout
  import cfbc_pkg::*;
#(
  parameter int NT = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               launch_i,
  input  pkt_t               pkt_i,
  input  logic [NT-1:0]      present_i,
  input  logic [NT-1:0]      ready_i,
  output logic [NT-1:0]      valid_o,
  output logic [RADDR_W-1:0] raddr_o,
  output logic [PKT_W-1:0]   data_o,
  output logic               busy_o
);
  logic [NT-1:0] pend;
  pkt_t          hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
      hold <= '0;
    end else if (launch_i) begin
      pend <= present_i;
      hold <= pkt_i;
    end else begin
      pend <= pend & ~ready_i;
    end
  end

  assign valid_o = pend;
  assign raddr_o = hold.raddr;
  assign data_o  = hold.data;
  assign busy_o  = |pend;

  AST_SKIP_ABSENT: assert property (@(posedge clk) disable iff (!rst_n)
    launch_i |=> ((valid_o & ~$past(present_i)) == '0)); // R5
  AST_NO_NEW_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !launch_i |=> ((valid_o & ~$past(valid_o)) == '0)); // R6
  AST_HOLD_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (|(valid_o & ~ready_i)) |=> ($stable(data_o) && $stable(raddr_o))); // R6
  AST_LAUNCH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    launch_i |-> !busy_o); // R7
endmodule

// File: rtl/cfbc_err.sv
module cfbc_err (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_i,
  input  logic bad_wr_i,
  output logic err_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) err_o <= 1'b0;
    else        err_o <= rd_i | bad_wr_i;
  end

  AST_ERR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_i |=> err_o); // R8
  AST_ERR_ON_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    bad_wr_i |=> err_o); // R9
endmodule

// File: rtl/cfbc_bcast.sv
module cfbc_bcast
  import cfbc_pkg::*;
#(
  parameter int                 NUM_TGT    = 15,
  parameter logic [RADDR_W-1:0] DATA_RADDR = 6'd2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_valid,
  output logic               wr_ready,
  input  logic               wr_win,
  input  logic [OFS_W-1:0]   wr_addr,
  input  logic [WORD_W-1:0]  wr_data,
  input  logic [STRB_W-1:0]  wr_strb,
  input  logic               rd_valid,
  output logic [WORD_W-1:0]  rd_data,
  output logic               access_err,
  input  logic [NUM_TGT-1:0] tgt_present,
  output logic [NUM_TGT-1:0] pkt_valid,
  input  logic [NUM_TGT-1:0] pkt_ready,
  output logic [RADDR_W-1:0] pkt_addr,
  output logic [PKT_W-1:0]   pkt_data
);
  logic wr_fire, well_formed, acc, bad_wr, launch, busy;
  pkt_t pkt;

  assign wr_ready    = !busy;
  assign wr_fire     = wr_valid && wr_ready;
  assign well_formed = (wr_strb == '1) && (wr_addr[1:0] == 2'b00);
  assign acc         = wr_fire && well_formed;
  assign bad_wr      = wr_fire && !well_formed;
  assign rd_data     = '0;

  cfbc_stage #(.DATA_RADDR(DATA_RADDR)) i_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_i    (acc),
    .win_i    (win_e'(wr_win)),
    .ofs_i    (wr_addr[OFS_W-1:2]),
    .data_i   (wr_data),
    .launch_o (launch),
    .pkt_o    (pkt)
  );

  cfbc_fanout #(.NT(NUM_TGT)) i_fanout (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch_i  (launch),
    .pkt_i     (pkt),
    .present_i (tgt_present),
    .ready_i   (pkt_ready),
    .valid_o   (pkt_valid),
    .raddr_o   (pkt_addr),
    .data_o    (pkt_data),
    .busy_o    (busy)
  );

  cfbc_err i_err (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_i     (rd_valid),
    .bad_wr_i (bad_wr),
    .err_o    (access_err)
  );

  AST_BAD_NO_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    bad_wr |=> ((pkt_valid & ~$past(pkt_valid)) == '0)); // R9
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (|pkt_valid) |-> !wr_ready); // R7
endmodule

// File: tb/test_cfbc_bcast.sv
module test_cfbc_bcast;
  localparam int NT = 15;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_valid = 1'b0, wr_ready, wr_win = 1'b0;
  logic [9:0]    wr_addr = '0;
  logic [31:0]   wr_data = '0;
  logic [3:0]    wr_strb = 4'hF;
  logic          rd_valid = 1'b0;
  logic [31:0]   rd_data;
  logic          access_err;
  logic [NT-1:0] tgt_present = '1, pkt_valid, pkt_ready = '1;
  logic [5:0]    pkt_addr;
  logic [127:0]  pkt_data;

  int errs = 0, checks = 0;
  logic [31:0] m [3];

  always #2 clk = ~clk;

  cfbc_bcast #(.NUM_TGT(NT)) i_cfbc_bcast (.*);

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input bit win, input logic [9:0] ofs, input logic [31:0] d,
                    input logic [3:0] strb, input bit with_rd);
    bit good;
    logic [1:0] idx;
    @(negedge clk);
    wr_valid = 1'b1; wr_win = win; wr_addr = ofs; wr_data = d; wr_strb = strb;
    rd_valid = with_rd;
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 1'b0; rd_valid = 1'b0;
    good = (strb == 4'hF) && (ofs[1:0] == 2'b00);
    idx  = ofs[3:2];
    chk(access_err == (!good || with_rd), "R8/R9 err", 128'(access_err), 128'(!good || with_rd));
    if (good && idx == 2'd3) begin
      chk(pkt_valid == tgt_present, "R3/R5 valid", 128'(pkt_valid), 128'(tgt_present));
      chk(pkt_addr == (win ? 6'd2 : ofs[9:4]), win ? "R4 addr" : "R3 addr",
          128'(pkt_addr), 128'(win ? 6'd2 : ofs[9:4]));
      chk(pkt_data == {d, m[2], m[1], m[0]}, "R2/R10 data", pkt_data, {d, m[2], m[1], m[0]});
    end else begin
      if (good) m[idx] = d;
      chk(pkt_valid == '0, "R2/R9 no packet", 128'(pkt_valid), 128'(0));
    end
  endtask

  task automatic after_one();
    @(negedge clk);
    chk(pkt_valid == '0 && wr_ready, "R6 single cycle", 128'(pkt_valid), 128'(0));
  endtask

  initial begin
    #(4 * 200000);
    errs++;
    $display("FAIL watchdog act=running exp=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    m[0] = '0; m[1] = '0; m[2] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(pkt_valid == '0, "R1 valid", 128'(pkt_valid), 128'(0));
    chk(!access_err && wr_ready, "R1 err/ready", 128'({access_err, wr_ready}), 128'(2'b01));
    chk(rd_data == '0, "R1 rd_data", 128'(rd_data), 128'(0));
    // R1 zero staging: only word 3 after reset
    wr(1'b0, 10'h0AC, 32'hCAFE_0003, 4'hF, 1'b0); after_one();
    // R2 lane order
    wr(1'b0, 10'h100, 32'h1111_0000, 4'hF, 1'b0);
    wr(1'b0, 10'h104, 32'h2222_0001, 4'hF, 1'b0);
    wr(1'b0, 10'h108, 32'h3333_0002, 4'hF, 1'b0);
    wr(1'b0, 10'h3FC, 32'h4444_0003, 4'hF, 1'b0); after_one();
    // R10 retained words
    wr(1'b0, 10'h01C, 32'h5555_0003, 4'hF, 1'b0); after_one();
    // R4 data window ignores offset bits
    wr(1'b1, 10'h3BC, 32'h6666_0003, 4'hF, 1'b0); after_one();
    // R9 bad strobe and misalignment leave staging untouched
    wr(1'b0, 10'h000, 32'hDEAD_0000, 4'h7, 1'b0);
    wr(1'b0, 10'h006, 32'hDEAD_0001, 4'hF, 1'b0);
    wr(1'b0, 10'h00C, 32'h7777_0003, 4'hF, 1'b0); after_one();
    // R8 read
    @(negedge clk); rd_valid = 1'b1;
    chk(rd_data == '0, "R8 rd_data", 128'(rd_data), 128'(0));
    @(negedge clk); rd_valid = 1'b0;
    chk(access_err, "R8 err", 128'(access_err), 128'(1));
    @(negedge clk);
    chk(!access_err, "R8 err pulse", 128'(access_err), 128'(0));
    // read in the same cycle as a launch
    wr(1'b0, 10'h2CC, 32'h8888_0003, 4'hF, 1'b1); after_one();
    // R5 no target present
    tgt_present = '0;
    wr(1'b0, 10'h04C, 32'h9999_0003, 4'hF, 1'b0);
    chk(wr_ready, "R5 no stall", 128'(wr_ready), 128'(1));
    // R6/R7 back-pressure
    tgt_present = 15'h0013; pkt_ready = '0;
    wr(1'b0, 10'h35C, 32'hAAAA_0003, 4'hF, 1'b0);
    chk(!wr_ready, "R7 stall", 128'(wr_ready), 128'(0));
    @(negedge clk);
    chk(pkt_valid == 15'h0013, "R6 hold valid", 128'(pkt_valid), 128'(15'h0013));
    chk(pkt_data == {32'hAAAA_0003, m[2], m[1], m[0]} && pkt_addr == 6'h35, "R6 hold data",
        pkt_data, {32'hAAAA_0003, m[2], m[1], m[0]});
    pkt_ready = 15'h0001;
    @(negedge clk);
    chk(pkt_valid == 15'h0012, "R6 partial accept", 128'(pkt_valid), 128'(15'h0012));
    chk(!wr_ready, "R7 still busy", 128'(wr_ready), 128'(0));
    pkt_ready = '1;
    @(negedge clk);
    chk(pkt_valid == '0 && wr_ready, "R7 release", 128'({pkt_valid, wr_ready}), 128'(1));
    // random traffic
    for (int i = 0; i < 200; i++) begin
      logic [9:0] ofs;
      logic [3:0] strb;
      tgt_present = NT'($urandom);
      ofs  = 10'($urandom);
      if ($urandom_range(0, 7) != 0) ofs[1:0] = 2'b00;
      if ($urandom_range(0, 2) == 0) ofs[3:2] = 2'd3;
      strb = ($urandom_range(0, 7) == 0) ? 4'($urandom) : 4'hF;
      wr(1'($urandom), ofs, $urandom, strb, ($urandom_range(0, 5) == 0));
      after_one();
    end
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule